// File: doc/BRIEF.md
# Delayed Load Writeback Unit

This block is the register-file write side of a pipeline that has a one-instruction load delay slot. A load does not update its destination when it retires. It parks a target index, a data word and a bit mask in a pending slot. That slot is folded into the register file when the next instruction retires. The fold keeps the old bits wherever the mask is clear and takes the loaded bits wherever it is set. As a result, partial-word loads can merge into the register they update.

The unit owns the register file: 32 words of 32 bits, with entry 0 always reading zero. Each cycle it accepts at most one retiring instruction. That instruction may carry an immediate register write, a new delayed load, or both. A flush input, raised on exception entry, drains the pending slot without retiring anything. Two combinational read ports show the file as it stands before the current cycle's updates. The pending value stays invisible to them until it commits. Decode, execution and the memory access are outside the block.

Top module: `dlw_writeback_unit`

## Requirements
- R1: After reset every register reads 0 on both read ports and `pend_idx` is 0, meaning no load is pending.
- R2: The read ports are combinational and return the contents before this cycle's updates; a value waiting in the pending slot is not visible until it commits.
- R3: A pending load commits as (old & ~mask) | (value & mask) into its target, at the next clock edge where `ret_valid` or `flush` is high.
- R4: A retirement with `ret_ld_en` high commits the previous pending load and makes the new target, value and mask pending (`pend_idx` shows the new target); in cycles with neither `ret_valid` nor `flush` the pending slot is held unchanged.
- R5: A retirement with `ret_ld_en` low commits the previous pending load and clears the slot to target 0.
- R6: `flush` commits the pending load and clears the slot; a retirement presented in the same cycle is dropped (neither its write nor its load takes effect).
- R7: When the pending commit and the retiring instruction's immediate write hit the same register in one cycle, the register ends with the immediate write's value.
- R8: Register 0 always reads 0; immediate writes to it are discarded and a load targeting it leaves every register unchanged.
- R9: `ret_ld_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. Byte and halfword values are taken from the low bits of `ret_ld_raw`, sign-extended from bit 7 / bit 15 when `ret_ld_uns` is 0 and zero-extended when it is 1; their mask is all ones and `ret_ld_mask` is ignored. A word load uses `ret_ld_raw` and `ret_ld_mask` as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (pre-update contents) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (pre-update contents) |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_wr_en | input | 1 | Retiring instruction writes a register immediately |
| ret_wr_idx | input | 5 | Immediate write target |
| ret_wr_data | input | 32 | Immediate write value |
| ret_ld_en | input | 1 | Retiring instruction is a delayed load |
| ret_ld_idx | input | 5 | Delayed load target |
| ret_ld_raw | input | 32 | Raw loaded data, right-aligned |
| ret_ld_size | input | 2 | Load size code (see R9) |
| ret_ld_uns | input | 1 | Zero-extend a byte or halfword load |
| ret_ld_mask | input | 32 | Merge mask for word loads |
| flush | input | 1 | Exception entry: drain the pending load |
| pend_idx | output | 5 | Target of the pending load, 0 when none |

## Verification
Two functions can act in the same cycle: the commit of the previous load and the retiring instruction's immediate write. They can land on the same register, and the immediate write must win. The bench provokes this by parking a load on a register and then retiring an instruction that writes that register directly. It also does this while the instruction carries a new load of its own. The outcome is judged by reading the register back through a read port after the edge. A second overlap comes from raising flush together with a valid retirement. In that case only the drained load may be seen in the file.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  parameter int DLW_W = 32;

  typedef enum logic [1:0] {
    LDSZ_BYTE  = 2'd0,
    LDSZ_HALF  = 2'd1,
    LDSZ_WORD  = 2'd2,
    LDSZ_WORD3 = 2'd3
  } ld_size_e;

  // Merge a committed load into the previous register contents.
  function automatic logic [DLW_W-1:0] merge_bits(
    input logic [DLW_W-1:0] old_v,
    input logic [DLW_W-1:0] new_v,
    input logic [DLW_W-1:0] mask_v
  );
    return (old_v & ~mask_v) | (new_v & mask_v);
  endfunction

  // Widen a right-aligned load value to a full word.
  function automatic logic [DLW_W-1:0] widen_value(
    input logic [DLW_W-1:0] raw,
    input ld_size_e         sz,
    input logic             uns
  );
    logic fill;
    case (sz)
      LDSZ_BYTE: begin
        fill = uns ? 1'b0 : raw[7];
        return {{(DLW_W-8){fill}}, raw[7:0]};
      end
      LDSZ_HALF: begin
        fill = uns ? 1'b0 : raw[15];
        return {{(DLW_W-16){fill}}, raw[15:0]};
      end
      default: return raw;
    endcase
  endfunction

  // Mask that accompanies a widened load.
  function automatic logic [DLW_W-1:0] widen_mask(
    input ld_size_e         sz,
    input logic [DLW_W-1:0] mask_in
  );
    if (sz == LDSZ_BYTE || sz == LDSZ_HALF) return '1;
    return mask_in;
  endfunction

endpackage

// File: rtl/dlw_loadfmt.sv
module dlw_loadfmt
  import dlw_pkg::*;
(
  input  logic [DLW_W-1:0] raw,
  input  logic [1:0]       size_code,
  input  logic             uns,
  input  logic [DLW_W-1:0] mask_in,
  output logic [DLW_W-1:0] val_out,
  output logic [DLW_W-1:0] mask_out
);
  ld_size_e sz;

  always_comb begin
    sz       = ld_size_e'(size_code);
    val_out  = widen_value(raw, sz, uns);
    mask_out = widen_mask(sz, mask_in);
  end
endmodule

// File: rtl/dlw_pending.sv
module dlw_pending
  import dlw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             load_new,
  input  logic [IDX_W-1:0] new_idx,
  input  logic [DLW_W-1:0] new_val,
  input  logic [DLW_W-1:0] new_mask,
  output logic [IDX_W-1:0] cur_idx,
  output logic [DLW_W-1:0] cur_val,
  output logic [DLW_W-1:0] cur_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_val  <= '0;
      cur_mask <= '0;
    end else if (advance) begin
      if (load_new) begin
        cur_idx  <= new_idx;
        cur_val  <= new_val;
        cur_mask <= new_mask;
      end else begin
        cur_idx  <= '0;
        cur_val  <= '0;
        cur_mask <= '0;
      end
    end
  end
endmodule

// File: rtl/dlw_regfile.sv
module dlw_regfile
  import dlw_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [DLW_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [DLW_W-1:0] rb_data,
  input  logic             cm_en,
  input  logic [IDX_W-1:0] cm_idx,
  input  logic [DLW_W-1:0] cm_val,
  input  logic [DLW_W-1:0] cm_mask,
  input  logic             dw_en,
  input  logic [IDX_W-1:0] dw_idx,
  input  logic [DLW_W-1:0] dw_data
);
  logic [DLW_W-1:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign view[g] = '0;
    end else begin : g_word
      logic [DLW_W-1:0] q;
      logic             dw_hit;
      logic             cm_hit;
      assign dw_hit = dw_en && (dw_idx == IDX_W'(g));
      assign cm_hit = cm_en && (cm_idx == IDX_W'(g));
      // The immediate write is applied after the commit, so it wins.
      always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (dw_hit) q <= dw_data;
        else if (cm_hit) q <= merge_bits(q, cm_val, cm_mask);
      end
      assign view[g] = q;
    end
  end

  assign ra_data = view[ra_idx];
  assign rb_data = view[rb_idx];
endmodule

// File: rtl/dlw_writeback_unit.sv
module dlw_writeback_unit
  import dlw_pkg::*;
#(
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DLW_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DLW_W-1:0] rd_b_data,
  input  logic             ret_valid,
  input  logic             ret_wr_en,
  input  logic [IDX_W-1:0] ret_wr_idx,
  input  logic [DLW_W-1:0] ret_wr_data,
  input  logic             ret_ld_en,
  input  logic [IDX_W-1:0] ret_ld_idx,
  input  logic [DLW_W-1:0] ret_ld_raw,
  input  logic [1:0]       ret_ld_size,
  input  logic             ret_ld_uns,
  input  logic [DLW_W-1:0] ret_ld_mask,
  input  logic             flush,
  output logic [IDX_W-1:0] pend_idx
);
  // Named internal events
  logic             advance;
  logic             accept;
  logic             load_new;
  logic             commit_fire;
  logic             direct_fire;
  logic [DLW_W-1:0] pend_val;
  logic [DLW_W-1:0] pend_mask;
  logic [DLW_W-1:0] fmt_val;
  logic [DLW_W-1:0] fmt_mask;

  assign advance     = ret_valid || flush;
  assign accept      = ret_valid && !flush;
  assign load_new    = accept && ret_ld_en;
  assign commit_fire = advance && (pend_idx != '0);
  assign direct_fire = accept && ret_wr_en && (ret_wr_idx != '0);

  dlw_loadfmt u_fmt (
    .raw       (ret_ld_raw),
    .size_code (ret_ld_size),
    .uns       (ret_ld_uns),
    .mask_in   (ret_ld_mask),
    .val_out   (fmt_val),
    .mask_out  (fmt_mask)
  );

  dlw_pending #(.IDX_W(IDX_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .load_new (load_new),
    .new_idx  (ret_ld_idx),
    .new_val  (fmt_val),
    .new_mask (fmt_mask),
    .cur_idx  (pend_idx),
    .cur_val  (pend_val),
    .cur_mask (pend_mask)
  );

  dlw_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (rd_a_idx),
    .ra_data (rd_a_data),
    .rb_idx  (rd_b_idx),
    .rb_data (rd_b_data),
    .cm_en   (commit_fire),
    .cm_idx  (pend_idx),
    .cm_val  (pend_val),
    .cm_mask (pend_mask),
    .dw_en   (direct_fire),
    .dw_idx  (ret_wr_idx),
    .dw_data (ret_wr_data)
  );
endmodule

// File: rtl/dlw_writeback_checker.sv
module dlw_writeback_checker
  import dlw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rd_a_idx,
  input logic [DLW_W-1:0] rd_a_data,
  input logic [IDX_W-1:0] rd_b_idx,
  input logic [DLW_W-1:0] rd_b_data,
  input logic             ret_valid,
  input logic             ret_wr_en,
  input logic [IDX_W-1:0] ret_wr_idx,
  input logic [DLW_W-1:0] ret_wr_data,
  input logic             ret_ld_en,
  input logic [IDX_W-1:0] ret_ld_idx,
  input logic             flush,
  input logic [IDX_W-1:0] pend_idx
);
  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0));  // R8
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == '0) |-> (rd_b_data == '0));  // R8
  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_idx == '0));  // R6
  AST_LOAD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && ret_ld_en) |=> (pend_idx == $past(ret_ld_idx)));  // R4
  AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && !ret_ld_en) |=> (pend_idx == '0));  // R5
  AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !flush) |=> $stable(pend_idx));  // R4
  AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && ret_wr_en && ret_wr_idx != '0)
      |=> ((rd_a_idx != $past(ret_wr_idx)) || (rd_a_data == $past(ret_wr_data))));  // R7
endmodule

bind dlw_writeback_unit dlw_writeback_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .ret_valid   (ret_valid),
  .ret_wr_en   (ret_wr_en),
  .ret_wr_idx  (ret_wr_idx),
  .ret_wr_data (ret_wr_data),
  .ret_ld_en   (ret_ld_en),
  .ret_ld_idx  (ret_ld_idx),
  .flush       (flush),
  .pend_idx    (pend_idx)
);

// File: tb/test_dlw_writeback_unit.sv
`timescale 1ns/1ps
module test_dlw_writeback_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        ret_valid = 1'b0, ret_wr_en = 1'b0, ret_ld_en = 1'b0, ret_ld_uns = 1'b0;
  logic [4:0]  ret_wr_idx = '0, ret_ld_idx = '0;
  logic [31:0] ret_wr_data = '0, ret_ld_raw = '0, ret_ld_mask = '0;
  logic [1:0]  ret_ld_size = '0;
  logic        flush = 1'b0;
  logic [4:0]  pend_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dlw_writeback_unit i_dlw_writeback_unit (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .ret_valid(ret_valid), .ret_wr_en(ret_wr_en), .ret_wr_idx(ret_wr_idx),
    .ret_wr_data(ret_wr_data), .ret_ld_en(ret_ld_en), .ret_ld_idx(ret_ld_idx),
    .ret_ld_raw(ret_ld_raw), .ret_ld_size(ret_ld_size), .ret_ld_uns(ret_ld_uns),
    .ret_ld_mask(ret_ld_mask), .flush(flush), .pend_idx(pend_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Read a register through both ports and compare.
  task automatic check_reg(input string req, input logic [4:0] idx, input logic [31:0] exp);
    rd_a_idx = idx;
    rd_b_idx = idx;
    #0.5;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic retire(input bit wr, input logic [4:0] widx, input logic [31:0] wdat,
                        input bit ld, input logic [4:0] lidx, input logic [31:0] raw,
                        input logic [1:0] sz, input bit uns, input logic [31:0] msk,
                        input bit fl = 1'b0);
    @(negedge clk);
    ret_valid = 1'b1; flush = fl;
    ret_wr_en = wr; ret_wr_idx = widx; ret_wr_data = wdat;
    ret_ld_en = ld; ret_ld_idx = lidx; ret_ld_raw = raw;
    ret_ld_size = sz; ret_ld_uns = uns; ret_ld_mask = msk;
    @(posedge clk);
    #1;
    ret_valid = 1'b0; flush = 1'b0; ret_wr_en = 1'b0; ret_ld_en = 1'b0;
  endtask

  task automatic nop();
    retire(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) check_reg("R1", 5'(i), 32'h0);
    check("R1", 32'(pend_idx), 0);
  endtask

  task automatic t_basic();
    retire(1, 5, 32'h1111_1111, 0, 0, 0, 0, 0, 0);
    retire(0, 0, 0, 1, 5, 32'hA5A5_5A5A, 2, 0, 32'hFFFF_FFFF);
    check_reg("R2", 5, 32'h1111_1111);
    check("R4", 32'(pend_idx), 5);
    idle();
    check("R4", 32'(pend_idx), 5);
    check_reg("R4", 5, 32'h1111_1111);
    nop();
    check_reg("R3", 5, 32'hA5A5_5A5A);
    check("R5", 32'(pend_idx), 0);
  endtask

  task automatic t_merge();
    retire(1, 6, 32'hAABB_CCDD, 0, 0, 0, 0, 0, 0);
    retire(0, 0, 0, 1, 6, 32'h1234_5678, 3, 0, 32'h0000_FFFF);
    nop();
    check_reg("R3", 6, 32'hAABB_5678);
  endtask

  task automatic t_chain();
    retire(0, 0, 0, 1, 7, 32'h7777_0007, 2, 0, 32'hFFFF_FFFF);
    retire(0, 0, 0, 1, 8, 32'h8888_0008, 2, 0, 32'hFFFF_FFFF);
    check_reg("R4", 7, 32'h7777_0007);
    check_reg("R4", 8, 32'h0);
    check("R4", 32'(pend_idx), 8);
    nop();
    check_reg("R5", 8, 32'h8888_0008);
  endtask

  task automatic t_conflict();
    retire(0, 0, 0, 1, 9, 32'hBAD0_BAD0, 2, 0, 32'hFFFF_FFFF);
    retire(1, 9, 32'h0000_C0DE, 0, 0, 0, 0, 0, 0);
    check_reg("R7", 9, 32'h0000_C0DE);
    retire(0, 0, 0, 1, 14, 32'hDEAD_0000, 2, 0, 32'hFFFF_FFFF);
    retire(1, 14, 32'h0000_00AB, 1, 15, 32'h0000_0F0F, 2, 0, 32'hFFFF_FFFF);
    check_reg("R7", 14, 32'h0000_00AB);
    check("R7", 32'(pend_idx), 15);
    nop();
    check_reg("R7", 15, 32'h0000_0F0F);
  endtask

  task automatic t_flush();
    retire(0, 0, 0, 1, 10, 32'h1010_1010, 2, 0, 32'hFFFF_FFFF);
    retire(1, 11, 32'h0000_DEAD, 1, 13, 32'h1313_1313, 2, 0, 32'hFFFF_FFFF, 1'b1);
    check_reg("R6", 10, 32'h1010_1010);
    check_reg("R6", 11, 32'h0);
    check("R6", 32'(pend_idx), 0);
    nop();
    check_reg("R6", 13, 32'h0);
  endtask

  task automatic t_zero();
    retire(1, 0, 32'hFFFF_FFFF, 1, 0, 32'hFFFF_FFFF, 2, 0, 32'hFFFF_FFFF);
    check_reg("R8", 0, 32'h0);
    check("R8", 32'(pend_idx), 0);
    nop();
    check_reg("R8", 0, 32'h0);
    check_reg("R8", 5, 32'hA5A5_5A5A);
  endtask

  task automatic t_extend();
    retire(1, 12, 32'h5555_5555, 1, 12, 32'h1234_56F0, 0, 0, 32'h0);
    nop();
    check_reg("R9", 12, 32'hFFFF_FFF0);
    retire(0, 0, 0, 1, 12, 32'h1234_56F0, 0, 1, 32'h0);
    nop();
    check_reg("R9", 12, 32'h0000_00F0);
    retire(0, 0, 0, 1, 12, 32'hABCD_8001, 1, 0, 32'h0000_00FF);
    nop();
    check_reg("R9", 12, 32'hFFFF_8001);
    retire(0, 0, 0, 1, 12, 32'hABCD_8001, 1, 1, 32'h0);
    nop();
    check_reg("R9", 12, 32'h0000_8001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_merge();
    t_chain();
    t_conflict();
    t_flush();
    t_zero();
    t_extend();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule